// File: doc/BRIEF.md
# Configurable Single-Port Synchronous RAM

This block is a single-port synchronous memory. Reads and writes share one address input, and an access can be a read, a write, or both at once on the same location. Two parameters fix the storage shape as depth by word width, chosen from a short list of shapes that all fit a 9-kilobit array. A third parameter decides what the read port returns when a read and a write to the same word occur in the same access.

Every access passes through an input register stage and then an output register, so a read returns one clock after its request is captured. The input stage and the output stage each have their own clock enable. An address-stall input keeps the captured address while other inputs keep flowing, which lets a write burst or a repeated read stay on one word. An asynchronous clear empties only the output register.

The memory is a random-access store, not a stream, so there is no valid/ready handshake. All control pins are plain level signals sampled on the rising clock edge, except the clear, which acts at once.

Top module: `cfg_spram`

## Requirements
- R1: Only these DEPTH x WIDTH shapes elaborate: 8192x1, 4096x2, 2048x4, 1024x8, 1024x9, 512x16, 512x18, 256x32 and 256x36. Any other pair is rejected during elaboration.
- R2: A request with `in_ce` and `rd_en` high at clock edge k makes `rdata` show the addressed word after edge k+1.
- R3: When no read is captured (`rd_en` or `in_ce` low at edge k), `rdata` keeps its value through edge k+1, and a write in that access does not change `rdata`.
- R4: With RDW_NEW_DATA=1, an access that reads and writes the same word returns the word as it is after the write. Enabled lanes show the new data and disabled lanes show the stored data.
- R5: With RDW_NEW_DATA=0, an access that reads and writes the same word returns the word as it was before the write.
- R6: Lane i is bits [i*L +: L] and `byte_en[i]` controls it. L is 9 when WIDTH is a multiple of 9, 8 for WIDTH 16 and 32, and WIDTH itself for widths below 8, which have one lane. A lane whose enable is low keeps its stored contents.
- R7: When `addr_stall` is high at a captured edge, `addr` is ignored. The read or write uses the previously captured address.
- R8: When `in_ce` is low at an edge, no write takes place, no read is issued, and the captured address stays the same.
- R9: When `out_ce` is low at edge k+1, `rdata` does not change at that edge. A read result due at that edge is dropped.
- R10: When `aclr` is high, `rdata` is zero at once, regardless of the clock. Memory contents are not changed by it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all registers |
| aclr | input | 1 | Asynchronous clear of the output register, active high |
| in_ce | input | 1 | Clock enable of the input stage and of writes |
| out_ce | input | 1 | Clock enable of the output register |
| addr | input | $clog2(DEPTH) | Shared read/write word address |
| addr_stall | input | 1 | High: keep the previously captured address |
| wr_en | input | 1 | Write request |
| rd_en | input | 1 | Read request |
| byte_en | input | lane count | Per-lane write enables |
| wdata | input | WIDTH | Write data |
| rdata | output | WIDTH | Registered read data |

## Verification
The bench runs two instances in parallel, one in new-data mode and one in old-data mode, on the 512x18 shape with two 9-bit lanes. A partial-lane write that is also read is where the two modes differ. A design that ignored the lane mask on the read bypass would show the whole new word, and a design that swapped the modes would fail on both instances. The bench also checks the idle paths. These are a write with reads off, which must not move `rdata`; `in_ce` low, which must neither write nor move the address; and `out_ce` low, which must drop the result. A design that gated the wrong stage would instead leak a stale or unintended word. Address stall is checked by writing with a different address on the bus and then reading both locations. Finally the clear is pulsed and memory is read back, which exposes a clear that also wiped the array.

// File: rtl/cfg_spram_pkg.sv
package cfg_spram_pkg;

  function automatic bit shape_ok(input int unsigned depth, input int unsigned width);
    return (depth == 8192 && width == 1)  || (depth == 4096 && width == 2)  ||
           (depth == 2048 && width == 4)  || (depth == 1024 && width == 8)  ||
           (depth == 1024 && width == 9)  || (depth == 512  && width == 16) ||
           (depth == 512  && width == 18) || (depth == 256  && width == 32) ||
           (depth == 256  && width == 36);
  endfunction

  function automatic int unsigned lane_bits(input int unsigned width);
    if (width % 9 == 0) return 9;
    else if (width < 8) return width;
    else return 8;
  endfunction

  function automatic int unsigned lane_count(input int unsigned width);
    return (width + lane_bits(width) - 1) / lane_bits(width);
  endfunction

endpackage

// File: rtl/spram_in_stage.sv
module spram_in_stage #(
  parameter int unsigned AW = 9,
  parameter int unsigned DW = 18,
  parameter int unsigned NL = 2
) (
  input  logic          clk,
  input  logic          aclr,
  input  logic          in_ce,
  input  logic          addr_stall,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [NL-1:0] byte_en,
  input  logic [DW-1:0] wdata,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q,
  output logic [NL-1:0] be_q,
  output logic          we_q,
  output logic          re_q
);

  always_ff @(posedge clk) begin
    if (in_ce) begin
      if (!addr_stall) addr_q <= addr;
      wdata_q <= wdata;
      be_q    <= byte_en;
      we_q    <= wr_en;
      re_q    <= rd_en;
    end else begin
      we_q <= 1'b0;
      re_q <= 1'b0;
    end
  end

  // R7: a stalled capture leaves the address register alone
  p_stall_hold_r7: assert property (@(posedge clk) disable iff (aclr)
    addr_stall |=> $stable(addr_q));

  // R8: input stage disabled keeps the address register
  p_ce_hold_r8: assert property (@(posedge clk) disable iff (aclr)
    !in_ce |=> $stable(addr_q));

  // R8: no access is issued from a disabled input stage
  p_ce_noop_r8: assert property (@(posedge clk) disable iff (aclr)
    !in_ce |=> (!we_q && !re_q));

endmodule

// File: rtl/spram_array.sv
module spram_array #(
  parameter int unsigned DEPTH        = 512,
  parameter int unsigned AW           = 9,
  parameter int unsigned DW           = 18,
  parameter int unsigned LW           = 9,
  parameter int unsigned NL           = 2,
  parameter bit          RDW_NEW_DATA = 1'b1
) (
  input  logic          clk,
  input  logic [AW-1:0] addr_q,
  input  logic [DW-1:0] wdata_q,
  input  logic [NL-1:0] be_q,
  input  logic          we_q,
  output logic [DW-1:0] rd_data
);

  logic [DW-1:0] store [DEPTH];
  logic [DW-1:0] cur_word;
  logic [DW-1:0] merged;

  assign cur_word = store[addr_q];

  for (genvar l = 0; l < NL; l++) begin : g_lane
    assign merged[l*LW +: LW] = be_q[l] ? wdata_q[l*LW +: LW] : cur_word[l*LW +: LW];
  end

  always_ff @(posedge clk) begin
    if (we_q) store[addr_q] <= merged;
  end

  if (RDW_NEW_DATA) begin : g_rdw_new
    assign rd_data = we_q ? merged : cur_word;
  end else begin : g_rdw_old
    assign rd_data = cur_word;
  end

endmodule

// File: rtl/spram_out_reg.sv
module spram_out_reg #(
  parameter int unsigned DW = 18
) (
  input  logic          clk,
  input  logic          aclr,
  input  logic          load,
  input  logic [DW-1:0] rd_data,
  output logic [DW-1:0] q
);

  always_ff @(posedge clk or posedge aclr) begin
    if (aclr)      q <= '0;
    else if (load) q <= rd_data;
  end

  // R10: clear holds the output at zero
  p_clear_zero_r10: assert property (@(posedge clk) aclr |-> (q == '0));

endmodule

// File: rtl/cfg_spram.sv
module cfg_spram #(
  parameter int unsigned DEPTH        = 512,
  parameter int unsigned WIDTH        = 18,
  parameter bit          RDW_NEW_DATA = 1'b1,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned LW = cfg_spram_pkg::lane_bits(WIDTH),
  localparam int unsigned NL = cfg_spram_pkg::lane_count(WIDTH)
) (
  input  logic             clk,
  input  logic             aclr,
  input  logic             in_ce,
  input  logic             out_ce,
  input  logic [AW-1:0]    addr,
  input  logic             addr_stall,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [NL-1:0]    byte_en,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata
);

  // R1: shape legality is enforced at elaboration
  if (!cfg_spram_pkg::shape_ok(DEPTH, WIDTH)) begin : g_bad_shape
    $error("cfg_spram: unsupported shape %0d x %0d", DEPTH, WIDTH);
  end

  logic [AW-1:0]    addr_q;
  logic [WIDTH-1:0] wdata_q;
  logic [NL-1:0]    be_q;
  logic             we_q;
  logic             re_q;
  logic [WIDTH-1:0] rd_data;

  spram_in_stage #(.AW(AW), .DW(WIDTH), .NL(NL)) u_in (
    .clk(clk), .aclr(aclr), .in_ce(in_ce), .addr_stall(addr_stall),
    .addr(addr), .wr_en(wr_en), .rd_en(rd_en), .byte_en(byte_en),
    .wdata(wdata), .addr_q(addr_q), .wdata_q(wdata_q), .be_q(be_q),
    .we_q(we_q), .re_q(re_q)
  );

  spram_array #(.DEPTH(DEPTH), .AW(AW), .DW(WIDTH), .LW(LW), .NL(NL),
                .RDW_NEW_DATA(RDW_NEW_DATA)) u_array (
    .clk(clk), .addr_q(addr_q), .wdata_q(wdata_q), .be_q(be_q),
    .we_q(we_q), .rd_data(rd_data)
  );

  spram_out_reg #(.DW(WIDTH)) u_out (
    .clk(clk), .aclr(aclr), .load(re_q && out_ce), .rd_data(rd_data), .q(rdata)
  );

  // R3: no captured read means no output change on the following edge
  p_hold_idle_r3: assert property (@(posedge clk) disable iff (aclr)
    !(rd_en && in_ce) |-> ##2 $stable(rdata));

  // R9: output enable low freezes the output register
  p_out_gate_r9: assert property (@(posedge clk) disable iff (aclr)
    !out_ce |=> $stable(rdata));

endmodule

// File: tb/cfg_spram_bench.sv
module cfg_spram_bench;

  localparam int unsigned DEPTH = 512;
  localparam int unsigned DW    = 18;
  localparam int unsigned AW    = 9;
  localparam int unsigned NL    = 2;
  localparam int unsigned LW    = 9;

  logic          clk = 1'b0;
  logic          aclr = 1'b1;
  logic          in_ce = 1'b1;
  logic          out_ce = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          addr_stall = 1'b0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [NL-1:0] byte_en = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] q_new;
  logic [DW-1:0] q_old;

  always #5 clk = ~clk;

  cfg_spram #(.DEPTH(DEPTH), .WIDTH(DW), .RDW_NEW_DATA(1'b1)) u_cfg_spram (
    .clk(clk), .aclr(aclr), .in_ce(in_ce), .out_ce(out_ce), .addr(addr),
    .addr_stall(addr_stall), .wr_en(wr_en), .rd_en(rd_en), .byte_en(byte_en),
    .wdata(wdata), .rdata(q_new)
  );

  cfg_spram #(.DEPTH(DEPTH), .WIDTH(DW), .RDW_NEW_DATA(1'b0)) u_cfg_spram_old (
    .clk(clk), .aclr(aclr), .in_ce(in_ce), .out_ce(out_ce), .addr(addr),
    .addr_stall(addr_stall), .wr_en(wr_en), .rd_en(rd_en), .byte_en(byte_en),
    .wdata(wdata), .rdata(q_old)
  );

  typedef struct {
    logic [DW-1:0] exp_new;
    logic [DW-1:0] exp_old;
    string         tag;
  } sb_item_t;

  sb_item_t sb[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference model state
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] m_a = '0;
  logic [AW-1:0] p_a = '0;
  logic [DW-1:0] p_d = '0;
  logic [NL-1:0] p_be = '0;
  bit            p_we = 1'b0;
  bit            p_re = 1'b0;
  logic [DW-1:0] e_new = '0;
  logic [DW-1:0] e_old = '0;

  function automatic logic [DW-1:0] merge(logic [DW-1:0] old, logic [DW-1:0] d,
                                          logic [NL-1:0] be);
    logic [DW-1:0] w = old;
    for (int l = 0; l < NL; l++) if (be[l]) w[l*LW +: LW] = d[l*LW +: LW];
    return w;
  endfunction

  task automatic check(string tag, string who, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s (%s): actual %h expected %h", tag, who, act, exp);
    end
  endtask

  // model of one rising edge with the inputs currently on the bus
  task automatic model_edge(bit clr);
    if (p_re && out_ce && !clr) begin
      e_old = mem[p_a];
      e_new = p_we ? merge(mem[p_a], p_d, p_be) : mem[p_a];
    end
    if (p_we) mem[p_a] = merge(mem[p_a], p_d, p_be);
    if (in_ce) begin
      if (!addr_stall) m_a = addr;
      p_a = m_a; p_d = wdata; p_be = byte_en; p_we = wr_en; p_re = rd_en;
    end else begin
      p_we = 1'b0; p_re = 1'b0;
    end
  endtask

  task automatic op(string tag, int a, logic [DW-1:0] d, bit we, logic [NL-1:0] be,
                    bit re, bit st = 1'b0, bit ice = 1'b1, bit oce = 1'b1);
    sb_item_t it;
    @(negedge clk);
    addr = a[AW-1:0]; wdata = d; wr_en = we; byte_en = be; rd_en = re;
    addr_stall = st; in_ce = ice; out_ce = oce;
    @(posedge clk);
    #1;
    model_edge(1'b0);
    it.exp_new = e_new; it.exp_old = e_old; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic idle(string tag);
    op(tag, 0, '0, 1'b0, '0, 1'b0, 1'b1);
  endtask

  task automatic pulse_clear();
    @(negedge clk);
    #1;
    aclr = 1'b1;
    wr_en = 1'b0; rd_en = 1'b0; addr_stall = 1'b1; in_ce = 1'b1; out_ce = 1'b1;
    #1;
    check("R10", "new", q_new, '0);
    check("R10", "old", q_old, '0);
    e_new = '0; e_old = '0;
    @(posedge clk);
    #1;
    model_edge(1'b1);
    @(negedge clk);
    #1;
    aclr = 1'b0;
  endtask

  // monitor: compare the design against the scoreboard after each edge
  initial begin
    sb_item_t it;
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        it = sb.pop_front();
        check(it.tag, "new", q_new, it.exp_new);
        check(it.tag, "old", q_old, it.exp_old);
      end
    end
  end

  initial begin
    for (int i = 0; i < int'(DEPTH); i++) mem[i] = '0;
    // reset: clear held, idle inputs
    for (int i = 0; i < 3; i++) begin
      @(posedge clk);
      #1;
      model_edge(1'b1);
    end
    check("R10", "new", q_new, '0);
    check("R10", "old", q_old, '0);
    @(negedge clk);
    #1;
    aclr = 1'b0;

    // R1: shape menu
    checks++; if (cfg_spram_pkg::shape_ok(512, 18) !== 1'b1) begin fails++; $display("FAIL R1: 512x18 actual 0 expected 1"); end
    checks++; if (cfg_spram_pkg::shape_ok(256, 36) !== 1'b1) begin fails++; $display("FAIL R1: 256x36 actual 0 expected 1"); end
    checks++; if (cfg_spram_pkg::shape_ok(512, 32) !== 1'b0) begin fails++; $display("FAIL R1: 512x32 actual 1 expected 0"); end
    checks++; if (cfg_spram_pkg::shape_ok(1000, 8) !== 1'b0) begin fails++; $display("FAIL R1: 1000x8 actual 1 expected 0"); end

    // fill, with reads off: output must not move (R3)
    op("R3", 9,  18'h00F0F, 1'b1, 2'b11, 1'b0);
    op("R3", 20, 18'h00155, 1'b1, 2'b11, 1'b0);
    op("R3", 5,  18'h2ABCD, 1'b1, 2'b11, 1'b0);
    // R2: plain reads, one clock after capture
    op("R2", 5,  '0, 1'b0, 2'b00, 1'b1);
    op("R2", 9,  '0, 1'b0, 2'b00, 1'b1);
    idle("R2");
    // R4 / R5: read and partial write of the same word
    op("R4_R5", 5, 18'h11111, 1'b1, 2'b01, 1'b1);
    idle("R4_R5");
    op("R4_R5", 20, 18'h3FE00, 1'b1, 2'b10, 1'b1);
    idle("R4_R5");
    // R6: upper lane only, then read back
    op("R6", 5, 18'h3FFFF, 1'b1, 2'b10, 1'b0);
    op("R6", 5, '0, 1'b0, 2'b00, 1'b1);
    idle("R6");
    // R7: stalled write lands on the held address 5, not 9
    op("R7", 9, 18'h0AAAA, 1'b1, 2'b11, 1'b0, 1'b1);
    op("R7", 9, '0, 1'b0, 2'b00, 1'b1);
    op("R7", 5, '0, 1'b0, 2'b00, 1'b1);
    idle("R7");
    // R8: input stage disabled: no write, no read, address held
    op("R8", 20, 18'h3FFFF, 1'b1, 2'b11, 1'b1, 1'b0, 1'b0);
    op("R8", 20, '0, 1'b0, 2'b00, 1'b1);
    op("R8", 9,  '0, 1'b0, 2'b00, 1'b1, 1'b0, 1'b0);
    op("R8", 0,  '0, 1'b0, 2'b00, 1'b1, 1'b1);
    idle("R8");
    // R9: read of 9 dropped by output enable low; read of 5 then shown
    op("R9", 9, '0, 1'b0, 2'b00, 1'b1);
    op("R9", 5, '0, 1'b0, 2'b00, 1'b1, 1'b0, 1'b1, 1'b0);
    idle("R9");
    idle("R9");
    // R10: clear leaves memory intact
    pulse_clear();
    op("R10", 5,  '0, 1'b0, 2'b00, 1'b1);
    op("R10", 20, '0, 1'b0, 2'b00, 1'b1);
    idle("R10");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule